// File: doc/BRIEF.md
# Asynchronous serial receiver with line-activity wake-up

This block receives 8N1 serial characters on a single RX line. It oversamples the line 16 times per bit, using a baud tick supplied from outside. A received byte is placed in a data register and raises a receive flag. The flag stays high until software reads the register. If the stop bit is sampled low, a framing-error flag is set alongside it. An idle status output tells software whether a character is currently being assembled.

For low-power use, software can arm a wake mode by pulsing a write strobe while the receiver is idle. While armed, the receiver decodes nothing. It watches the synchronized RX line for a falling edge, which needs neither the baud tick nor any other slow timing. The first falling edge raises the receive flag and loads the data register with dummy data, 0x00. The wake mode then disarms itself on the next rising edge of RX. The wake character should hold the line low for at least 8 bit times, or 12 for a break-style signal. A rising edge that comes sooner ends the wake phase at that point. After disarming, the next falling edge starts ordinary reception.

Top module: `uart_wake_rx`

## Requirements
- R1: With wake mode off, a falling edge on RX starts a frame. The start bit is confirmed on the 8th baud tick, and 8 data bits are then sampled LSB first, one every 16 ticks. When the stop bit is sampled, `rx_data` takes the byte and `rx_flag` goes high.
- R2: If RX is high again when the start bit is confirmed on the 8th tick, the frame is dropped. The receiver returns to idle and `rx_flag` is not set.
- R3: A stop bit sampled low sets `frame_err` together with `rx_flag`. The byte is still stored. `frame_err` is never high while `rx_flag` is low.
- R4: A one-cycle `rd_data` pulse clears both `rx_flag` and `frame_err`. Without a read they hold. If a read falls in the same cycle as a new flag-setting event, the flag ends up set.
- R5: `rx_idle` is high exactly when no frame is being assembled.
- R6: A `wake_set` pulse while `rx_idle` is high sets `wake_en`. A pulse during reception is ignored: `wake_en` stays low and the frame completes with correct data.
- R7: While `wake_en` is high, no frame is assembled, even with the baud tick running and RX held low for 12 bit times. `rx_idle` stays high, and no framing error arises.
- R8: The first falling edge of RX while `wake_en` is high sets `rx_flag` and loads `rx_data` with 0x00. This happens within 3 clocks and with `baud_tick` held low.
- R9: `wake_en` clears on the first rising edge of RX after the wake event, however short the low phase was. It stays high while the synchronized line is low.
- R10: Once `wake_en` has cleared, the next falling edge starts a normal frame as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| rx | input | 1 | Serial input, idle high, asynchronous |
| wake_set | input | 1 | Write strobe that arms wake mode |
| rd_data | input | 1 | Read strobe of the data register |
| wake_en | output | 1 | Wake mode armed |
| rx_data | output | 8 | Received byte, or 0x00 after a wake event |
| rx_flag | output | 1 | Receive interrupt flag |
| rx_idle | output | 1 | No frame in progress |
| frame_err | output | 1 | Last stored frame had a low stop bit |

## Verification
The read strobe and the wake-event flag set can land in the same clock cycle. The bench provokes this by raising `rd_data` in the cycle where the second synchronizer stage first shows RX low, which is two clock cycles after it drives RX low. It then expects `rx_flag` to be high. A later isolated read must clear it, which shows that the earlier read really coincided with the set. All 256 byte values are also swept through normal reception, each followed by a read.

// File: rtl/uart_wake_rx.sv
module uart_wake_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx,
  input  logic          wake_set,
  input  logic          rd_data,
  output logic          wake_en,
  output logic [DW-1:0] rx_data,
  output logic          rx_flag,
  output logic          rx_idle,
  output logic          frame_err
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;
  st_t st;

  logic s1, s2, sp, woke;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bits;
  logic [DW-1:0] shr;

  wire fall     = sp & ~s2;
  wire rise     = ~sp & s2;
  wire idle     = (st == S_IDLE);
  wire go       = idle & ~wake_en & fall;
  wire arm      = wake_set & idle & ~wake_en & ~go;
  wire wake_hit = wake_en & ~woke & fall;
  wire mid      = baud_tick && cnt == CW'(OVS/2 - 1);
  wire last     = baud_tick && cnt == CW'(OVS - 1);
  wire done     = (st == S_STOP) & last;

  assign rx_idle = idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, sp} <= 3'b111;
    else        {s1, s2, sp} <= {rx, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_en <= 1'b0;
      woke    <= 1'b0;
    end else if (arm) begin
      wake_en <= 1'b1;
      woke    <= 1'b0;
    end else if (wake_hit) begin
      woke    <= 1'b1;
    end else if (wake_en && woke && rise) begin
      wake_en <= 1'b0;
      woke    <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bits <= '0;
      shr  <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (baud_tick) begin
          cnt <= cnt + 1'b1;
          if (mid) begin
            cnt  <= '0;
            bits <= '0;
            st   <= s2 ? S_IDLE : S_DATA;
          end
        end
        S_DATA: if (baud_tick) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            cnt  <= '0;
            shr  <= {s2, shr[DW-1:1]};
            bits <= bits + 1'b1;
            if (bits == BW'(DW - 1)) st <= S_STOP;
          end
        end
        S_STOP: if (baud_tick) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            cnt <= '0;
            st  <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data   <= '0;
      rx_flag   <= 1'b0;
      frame_err <= 1'b0;
    end else if (done) begin
      rx_data   <= shr;
      rx_flag   <= 1'b1;
      frame_err <= ~s2;
    end else if (wake_hit) begin
      rx_data   <= '0;
      rx_flag   <= 1'b1;
      frame_err <= 1'b0;
    end else if (rd_data) begin
      rx_flag   <= 1'b0;
      frame_err <= 1'b0;
    end
endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic wake_en,
  input logic rx_idle,
  input logic rx_flag,
  input logic frame_err,
  input logic rd_data,
  input logic wake_set,
  input logic rx_sync
);
  a_r7_idle_while_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |-> rx_idle);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !rd_data |=> rx_flag);

  a_r9_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en && !rx_sync |=> wake_en);

  a_r6_no_arm_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_idle && wake_set |=> !wake_en);

  a_r3_ferr_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> rx_flag);
endmodule

bind uart_wake_rx uart_wake_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .rx_idle(rx_idle),
  .rx_flag(rx_flag), .frame_err(frame_err), .rd_data(rd_data),
  .wake_set(wake_set), .rx_sync(s2)
);

// File: tb/sim_uart_wake_rx.sv
module sim_uart_wake_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT = 32;

  logic clk = 0, rst_n = 0, baud_tick = 0, rx = 1, wake_set = 0, rd_data = 0;
  logic wake_en, rx_flag, rx_idle, frame_err;
  logic [7:0] rx_data;
  logic tick_on = 1, tdiv = 0;
  int checks = 0, errors = 0;

  uart_wake_rx u0 (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx(rx),
    .wake_set(wake_set), .rd_data(rd_data), .wake_en(wake_en), .rx_data(rx_data),
    .rx_flag(rx_flag), .rx_idle(rx_idle), .frame_err(frame_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv = ~tdiv;
    baud_tick = tick_on & tdiv;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_reg();
    @(negedge clk) rd_data = 1;
    @(negedge clk) rd_data = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input int poke);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) rx = fr[i];
      if (i == poke) begin
        clocks(9);
        wake_set = 1;
        @(negedge clk) wake_set = 0;
        chk(wake_en == 0, "R6 wake write ignored while busy", wake_en, 0);
        chk(rx_idle == 0, "R5 busy during frame", rx_idle, 0);
        clocks(BIT - 12);
      end else clocks(BIT - 1);
    end
    @(negedge clk) rx = 1;
    if (!stop) clocks(BIT);
    clocks(4);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clocks(3);
    rst_n = 1;
    clocks(2);
    chk(wake_en == 0 && rx_flag == 0 && frame_err == 0, "R4 reset flags", {wake_en, rx_flag, frame_err}, 0);
    chk(rx_idle == 1, "R5 idle after reset", rx_idle, 1);

    for (int b = 0; b < 256; b++) begin
      send(b[7:0], 1, -1);
      chk(rx_flag && rx_data == b[7:0] && !frame_err, "R1 byte received", {rx_flag, frame_err, rx_data}, {2'b10, b[7:0]});
      read_reg();
      chk(rx_flag == 0, "R4 read clears flag", rx_flag, 0);
    end

    // R2 glitch shorter than half a bit
    @(negedge clk) rx = 0;
    clocks(8);
    rx = 1;
    clocks(64);
    chk(rx_idle == 1 && rx_flag == 0, "R2 false start dropped", {rx_idle, rx_flag}, 2'b10);

    // R3 framing error
    send(8'h3C, 0, -1);
    chk(rx_flag && frame_err && rx_data == 8'h3C, "R3 framing error", {rx_flag, frame_err, rx_data}, {2'b11, 8'h3C});
    clocks(20);
    chk(rx_flag && frame_err, "R4 flags hold without read", {rx_flag, frame_err}, 2'b11);
    read_reg();
    chk(!rx_flag && !frame_err, "R4 read clears both", {rx_flag, frame_err}, 0);

    // R6 wake write during reception
    send(8'h96, 1, 4);
    chk(rx_flag && rx_data == 8'h96 && !wake_en, "R6 frame completes", {wake_en, rx_flag, rx_data}, {2'b01, 8'h96});
    read_reg();

    // R8 wake event with baud tick stopped
    tick_on = 0;
    wake_set = 1;
    @(negedge clk) wake_set = 0;
    chk(wake_en == 1 && rx_idle == 1, "R6 wake armed when idle", {wake_en, rx_idle}, 2'b11);
    @(negedge clk) rx = 0;
    clocks(3);
    chk(rx_flag == 1 && rx_data == 8'h00, "R8 wake flag and dummy data", {rx_flag, rx_data}, {1'b1, 8'h00});
    clocks(8 * BIT);
    chk(wake_en == 1, "R9 wake held while low", wake_en, 1);
    rx = 1;
    clocks(4);
    chk(wake_en == 0, "R9 wake cleared on rise", wake_en, 0);
    read_reg();
    chk(rx_flag == 0, "R4 dummy read clears flag", rx_flag, 0);
    tick_on = 1;

    // R7 long low phase with ticks running
    wake_set = 1;
    @(negedge clk) wake_set = 0;
    @(negedge clk) rx = 0;
    for (int k = 0; k < 12; k++) begin
      clocks(BIT);
      chk(rx_idle == 1 && wake_en == 1, "R7 no decoding while armed", {rx_idle, wake_en}, 2'b11);
    end
    rx = 1;
    clocks(BIT);
    chk(!wake_en && rx_flag && !frame_err && rx_data == 8'h00, "R7 no frame after wake", {wake_en, rx_flag, frame_err, rx_data}, {3'b010, 8'h00});
    read_reg();

    // R10 normal reception after wake
    send(8'hA5, 1, -1);
    chk(rx_flag && rx_data == 8'hA5, "R10 reception resumes", {rx_flag, rx_data}, {1'b1, 8'hA5});
    read_reg();

    // R9 short wake pulse
    wake_set = 1;
    @(negedge clk) wake_set = 0;
    @(negedge clk) rx = 0;
    clocks(5);
    rx = 1;
    clocks(5);
    chk(wake_en == 0 && rx_flag == 1, "R9 early rise ends wake", {wake_en, rx_flag}, 2'b01);
    read_reg();

    // R4 read in the same cycle as the wake flag set
    wake_set = 1;
    @(negedge clk) wake_set = 0;
    clocks(2);
    rx = 0;
    clocks(2);
    rd_data = 1;
    @(negedge clk) rd_data = 0;
    chk(rx_flag == 1, "R4 set wins over read", rx_flag, 1);
    clocks(3);
    rx = 1;
    clocks(4);
    read_reg();
    chk(rx_flag == 0 && wake_en == 0, "R4 later read clears", {rx_flag, wake_en}, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule